// File: doc/BRIEF.md
# TLB Access Permission Checker

This block sits after the address-translation lookup of a processor's memory unit. It takes the hit or miss results of a small instruction TLB and of a unified TLB, together with the attributes of whichever entry each one matched. It then decides whether the access may go ahead. From the access kind, the privileged-mode flag and the matched entry's protection bits, dirty bit, page number and page size, it produces three registered results: a fault code, a set of granted permissions, and the composed physical address.

The lookup logic also needs a simple combinational hint from this block. The hint says whether the address-space identifier has to take part in tag comparison.

Top module: `tlb_perm_check`

## Requirements
- R1: `asid_cmp_en` is 0 only when `sv_mode` and `priv` are both 1. In every other case it is 1, with no clock delay.
- R2: Access kinds are encoded as 0 = load, 1 = store, 2 = instruction fetch, and 3 = treated as a load. A fetch that hits in the instruction TLB uses the instruction-TLB entry, whatever the unified TLB reports.
- R3: A fetch that misses in the instruction TLB uses the unified-TLB entry. If both miss, the fault code is 1 (instruction miss).
- R4: A fetch that hits with `priv`=0 on an entry whose protection bit 1 is clear gives fault 2 (instruction violation). Otherwise it succeeds with permissions exactly 3'b100 (bit 2 = execute, bit 1 = write, bit 0 = read).
- R5: A data access that hits with `priv`=0 on an entry whose protection bit 1 is clear gives fault 5 for a load and fault 6 for a store.
- R6: A store that passes the R5 check but hits an entry whose protection bit 0 is clear gives fault 6 (write violation).
- R7: A store that passes the R5 and R6 checks but hits an entry whose dirty bit is clear gives fault 7 (initial write).
- R8: A data access that misses in the unified TLB gives fault 3 for a load and fault 4 for a store. The instruction-TLB inputs have no effect on data accesses.
- R9: A successful data access is granted read (bit 0). It is also granted write (bit 1) exactly when protection bit 0 is set, for loads as well as stores.
- R10: On success, the physical address is the entry's page number shifted left by 10 with the low page bits cleared, ORed with the virtual address bits below the page size. The size codes 0, 1, 2 and 3 select page offsets of 10, 12, 16 and 20 bits.
- R11: `rsp_valid` is high exactly on the cycle after a cycle with `req_valid` high, and carries that request's results. A response with a fault (non-zero code) has zero permissions and a zero physical address.
- R12: After a synchronous reset, `rsp_valid`, `rsp_fault`, `rsp_perm` and `rsp_paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sv_mode | input | 1 | Single-virtual-space mode enable |
| priv | input | 1 | Processor is in privileged mode |
| asid_cmp_en | output | 1 | Address-space identifier must join tag comparison |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_vaddr | input | VA_W | Virtual address |
| itlb_hit | input | 1 | Instruction TLB matched |
| itlb_pr | input | 2 | Instruction TLB entry protection bits |
| itlb_ppn | input | PA_W-10 | Instruction TLB entry page number |
| itlb_size | input | 2 | Instruction TLB entry size code |
| utlb_hit | input | 1 | Unified TLB matched |
| utlb_pr | input | 2 | Unified TLB entry protection bits |
| utlb_dirty | input | 1 | Unified TLB entry dirty bit |
| utlb_ppn | input | PA_W-10 | Unified TLB entry page number |
| utlb_size | input | 2 | Unified TLB entry size code |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_fault | output | 4 | Fault code, 0 = OK |
| rsp_perm | output | 3 | Granted permissions {exec, write, read} |
| rsp_paddr | output | PA_W | Composed physical address |

## Verification
Every registered result (fault code, permissions, physical address and valid pulse) belongs to the request presented one rising edge earlier. The bench drives a request on a falling edge and compares all four outputs on the following falling edge, before it drives the next request. On the falling edge after a request is withdrawn, it confirms that the valid pulse has dropped. The address-identifier hint is combinational, so it is checked a short delay after its inputs change, with no clock edge in between.

// File: rtl/tlbpc_pkg.sv
package tlbpc_pkg;

    localparam int PAGE_BASE_SHIFT = 10;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    typedef enum logic [3:0] {
        FLT_OK        = 4'd0,
        FLT_I_MISS    = 4'd1,
        FLT_I_VIOL    = 4'd2,
        FLT_D_MISS_RD = 4'd3,
        FLT_D_MISS_WR = 4'd4,
        FLT_D_VIOL_RD = 4'd5,
        FLT_D_VIOL_WR = 4'd6,
        FLT_FIRST_WR  = 4'd7
    } fault_e;

    typedef struct packed {
        logic       exec;
        logic       wr;
        logic       rd;
    } perm_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] pr;
        logic       dirty;
        logic [1:0] size;
    } ent_attr_t;

    function automatic logic [4:0] page_shift(input logic [1:0] code);
        logic [4:0] sh;
        case (code)
            2'd0:    sh = 5'd10;
            2'd1:    sh = 5'd12;
            2'd2:    sh = 5'd16;
            default: sh = 5'd20;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/tlbpc_judge.sv
module tlbpc_judge
    import tlbpc_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      priv,
    input  ent_attr_t iattr,
    input  ent_attr_t uattr,
    output logic      use_itlb,
    output fault_e    fault,
    output perm_t     perm
);

    logic is_fetch;
    logic is_store;
    logic src_hit;
    logic user_blocked;

    assign is_fetch = (kind == ACC_FETCH);
    assign is_store = (kind == ACC_STORE);

    always_comb begin
        use_itlb = is_fetch && iattr.hit;
        src_hit  = use_itlb ? 1'b1 : uattr.hit;
        user_blocked = !priv && !(use_itlb ? iattr.pr[1] : uattr.pr[1]);
    end

    always_comb begin
        fault = FLT_OK;
        perm  = '0;
        if (is_fetch) begin
            if (!src_hit) begin
                fault = FLT_I_MISS;
            end else if (user_blocked) begin
                fault = FLT_I_VIOL;
            end else begin
                perm.exec = 1'b1;
            end
        end else begin
            if (!uattr.hit) begin
                fault = is_store ? FLT_D_MISS_WR : FLT_D_MISS_RD;
            end else if (user_blocked) begin
                fault = is_store ? FLT_D_VIOL_WR : FLT_D_VIOL_RD;
            end else if (is_store && !uattr.pr[0]) begin
                fault = FLT_D_VIOL_WR;
            end else if (is_store && !uattr.dirty) begin
                fault = FLT_FIRST_WR;
            end else begin
                perm.rd = 1'b1;
                perm.wr = uattr.pr[0];
            end
        end
    end

endmodule

// File: rtl/tlbpc_compose.sv
module tlbpc_compose
    import tlbpc_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 29,
    localparam int PPN_W = PA_W - PAGE_BASE_SHIFT
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic             use_itlb,
    input  logic [PPN_W-1:0] ippn,
    input  logic [1:0]       isize,
    input  logic [PPN_W-1:0] uppn,
    input  logic [1:0]       usize,
    output logic [PA_W-1:0]  paddr
);

    logic [PPN_W-1:0] ppn_sel;
    logic [1:0]       size_sel;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  frame;
    logic [PA_W-1:0]  va_low;

    always_comb begin
        ppn_sel  = use_itlb ? ippn  : uppn;
        size_sel = use_itlb ? isize : usize;
        off_mask = (PA_W'(1) << page_shift(size_sel)) - PA_W'(1);
        frame    = {ppn_sel, {PAGE_BASE_SHIFT{1'b0}}};
        va_low   = vaddr[PA_W-1:0];
        paddr    = (frame & ~off_mask) | (va_low & off_mask);
    end

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlbpc_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 29,
    localparam int PPN_W = PA_W - PAGE_BASE_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sv_mode,
    input  logic             priv,
    output logic             asid_cmp_en,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             itlb_hit,
    input  logic [1:0]       itlb_pr,
    input  logic [PPN_W-1:0] itlb_ppn,
    input  logic [1:0]       itlb_size,
    input  logic             utlb_hit,
    input  logic [1:0]       utlb_pr,
    input  logic             utlb_dirty,
    input  logic [PPN_W-1:0] utlb_ppn,
    input  logic [1:0]       utlb_size,
    output logic             rsp_valid,
    output logic [3:0]       rsp_fault,
    output logic [2:0]       rsp_perm,
    output logic [PA_W-1:0]  rsp_paddr
);

    ent_attr_t       iattr;
    ent_attr_t       uattr;
    logic            use_itlb;
    fault_e          fault_c;
    perm_t           perm_c;
    logic [PA_W-1:0] paddr_c;

    assign asid_cmp_en = !(sv_mode && priv);

    always_comb begin
        iattr = '{hit: itlb_hit, pr: itlb_pr, dirty: 1'b1, size: itlb_size};
        uattr = '{hit: utlb_hit, pr: utlb_pr, dirty: utlb_dirty, size: utlb_size};
    end

    tlbpc_judge u_judge (
        .kind     (acc_kind_e'(req_kind)),
        .priv     (priv),
        .iattr    (iattr),
        .uattr    (uattr),
        .use_itlb (use_itlb),
        .fault    (fault_c),
        .perm     (perm_c)
    );

    tlbpc_compose #(.VA_W(VA_W), .PA_W(PA_W)) u_compose (
        .vaddr    (req_vaddr),
        .use_itlb (use_itlb),
        .ippn     (itlb_ppn),
        .isize    (itlb_size),
        .uppn     (utlb_ppn),
        .usize    (utlb_size),
        .paddr    (paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= '0;
            rsp_perm  <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= fault_c;
                rsp_perm  <= perm_c;
                rsp_paddr <= (fault_c == FLT_OK) ? paddr_c : '0;
            end
        end
    end

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_fault_zeroes_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 4'd0) |-> (rsp_perm == 3'd0 && rsp_paddr == '0));
    assert_exec_alone_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_perm[2]) |-> (rsp_perm[1:0] == 2'b00));
    assert_clean_store_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1 && utlb_hit && !utlb_dirty) |=> (rsp_fault != 4'd0));
    assert_data_miss_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind != 2'd2 && !utlb_hit) |=> (rsp_fault == 4'd3 || rsp_fault == 4'd4));

endmodule

// File: tb/tlb_perm_check_test.sv
module tlb_perm_check_test;

    localparam int CLK_PERIOD = 10;
    localparam int VA_W  = 32;
    localparam int PA_W  = 29;
    localparam int PPN_W = PA_W - 10;

    logic             clk = 1'b0;
    logic             rst;
    logic             sv_mode, priv, asid_cmp_en;
    logic             req_valid;
    logic [1:0]       req_kind;
    logic [VA_W-1:0]  req_vaddr;
    logic             itlb_hit, utlb_hit, utlb_dirty;
    logic [1:0]       itlb_pr, utlb_pr, itlb_size, utlb_size;
    logic [PPN_W-1:0] itlb_ppn, utlb_ppn;
    logic             rsp_valid;
    logic [3:0]       rsp_fault;
    logic [2:0]       rsp_perm;
    logic [PA_W-1:0]  rsp_paddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_perm_check #(.VA_W(VA_W), .PA_W(PA_W)) uut (
        .clk(clk), .rst(rst), .sv_mode(sv_mode), .priv(priv),
        .asid_cmp_en(asid_cmp_en), .req_valid(req_valid), .req_kind(req_kind),
        .req_vaddr(req_vaddr), .itlb_hit(itlb_hit), .itlb_pr(itlb_pr),
        .itlb_ppn(itlb_ppn), .itlb_size(itlb_size), .utlb_hit(utlb_hit),
        .utlb_pr(utlb_pr), .utlb_dirty(utlb_dirty), .utlb_ppn(utlb_ppn),
        .utlb_size(utlb_size), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int off_bits(input logic [1:0] c);
        return (c == 2'd0) ? 10 : (c == 2'd1) ? 12 : (c == 2'd2) ? 16 : 20;
    endfunction

    // Reference model written from the requirements.
    task automatic expect_result(output logic [3:0] f, output logic [2:0] p,
                                 output logic [31:0] pa, output string tag);
        logic [1:0] pr; logic [PPN_W-1:0] pn; logic [1:0] sz; logic hit;
        logic store, fetch;
        longint base, mask;
        fetch = (req_kind == 2'd2);
        store = (req_kind == 2'd1);
        f = 0; p = 0; pa = 0;
        if (fetch && itlb_hit) begin
            hit = 1; pr = itlb_pr; pn = itlb_ppn; sz = itlb_size; tag = "R2";
        end else begin
            hit = utlb_hit; pr = utlb_pr; pn = utlb_ppn; sz = utlb_size;
            tag = fetch ? "R3" : "R9";
        end
        if (fetch) begin
            if (!hit) f = 1;
            else if (!priv && !pr[1]) begin f = 2; tag = "R4"; end
            else p = 3'b100;
        end else begin
            if (!hit) begin f = store ? 4 : 3; tag = "R8"; end
            else if (!priv && !pr[1]) begin f = store ? 6 : 5; tag = "R5"; end
            else if (store && !pr[0]) begin f = 6; tag = "R6"; end
            else if (store && !utlb_dirty) begin f = 7; tag = "R7"; end
            else p = {1'b0, pr[0], 1'b1};
        end
        if (f == 0) begin
            mask = (64'd1 << off_bits(sz)) - 1;
            base = longint'(pn) << 10;
            pa = 32'((base & ~mask) | (longint'(req_vaddr) & mask));
            if (tag != "R2" && tag != "R3" && sz != 2'd0) tag = "R10";
        end
    endtask

    // Drive at a falling edge; results checked at the next falling edge.
    task automatic run_req();
        logic [3:0] ef; logic [2:0] ep; logic [31:0] epa; string tg;
        req_valid = 1'b1;
        expect_result(ef, ep, epa, tg);
        @(negedge clk);
        chk({"R11 valid ", tg}, 32'(rsp_valid), 32'd1);
        chk({tg, " fault"}, 32'(rsp_fault), 32'(ef));
        chk({tg, " perm"}, 32'(rsp_perm), 32'(ep));
        chk({tg, " paddr"}, 32'(rsp_paddr), epa);
        req_valid = 1'b0;
    endtask

    task automatic set_all(input logic [1:0] k, input logic pv, input logic ih,
                           input logic [1:0] ipr, input logic uh, input logic [1:0] upr,
                           input logic ud);
        req_kind = k; priv = pv; itlb_hit = ih; itlb_pr = ipr;
        utlb_hit = uh; utlb_pr = upr; utlb_dirty = ud;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; sv_mode = 0; req_valid = 0;
        set_all(2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
        req_vaddr = 32'h1234_5678; itlb_ppn = 19'h1_1111; utlb_ppn = 19'h2_2222;
        itlb_size = 2'd1; utlb_size = 2'd1;
        repeat (3) @(negedge clk);
        chk("R12 valid", 32'(rsp_valid), 0);
        chk("R12 fault", 32'(rsp_fault), 0);
        chk("R12 perm",  32'(rsp_perm), 0);
        chk("R12 paddr", 32'(rsp_paddr), 0);
        rst = 0;

        // R1: all four combinations of mode and privilege
        for (int i = 0; i < 4; i++) begin
            sv_mode = i[0]; priv = i[1]; #1;
            chk("R1 asid_cmp_en", 32'(asid_cmp_en), (i == 3) ? 0 : 1);
        end
        @(negedge clk);

        // R2: instruction TLB wins even when unified TLB would fault
        set_all(2'd2, 1'b0, 1'b1, 2'b10, 1'b0, 2'b00, 1'b0); run_req();
        // R3: fall back to unified TLB, and double miss
        set_all(2'd2, 1'b1, 1'b0, 2'b00, 1'b1, 2'b00, 1'b0); run_req();
        set_all(2'd2, 1'b1, 1'b0, 2'b11, 1'b0, 2'b11, 1'b1); run_req();
        // R4: user fetch violation
        set_all(2'd2, 1'b0, 1'b1, 2'b01, 1'b1, 2'b11, 1'b1); run_req();
        // R5: user load and store violations
        set_all(2'd0, 1'b0, 1'b1, 2'b11, 1'b1, 2'b01, 1'b1); run_req();
        set_all(2'd1, 1'b0, 1'b1, 2'b11, 1'b1, 2'b01, 1'b1); run_req();
        // R6: read-only store
        set_all(2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, 1'b1); run_req();
        // R7: clean page store, and R6 outranks R7
        set_all(2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 1'b0); run_req();
        set_all(2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0); run_req();
        // R8: data misses; instruction TLB hit must not matter
        set_all(2'd0, 1'b1, 1'b1, 2'b11, 1'b0, 2'b11, 1'b1); run_req();
        set_all(2'd1, 1'b1, 1'b1, 2'b11, 1'b0, 2'b11, 1'b1); run_req();
        // R9: load on read-only page, load on writable page, kind 3
        set_all(2'd0, 1'b1, 1'b0, 2'b00, 1'b1, 2'b10, 1'b0); run_req();
        set_all(2'd3, 1'b0, 1'b1, 2'b11, 1'b1, 2'b11, 1'b0); run_req();
        // R10: each page size
        for (int s = 0; s < 4; s++) begin
            utlb_size = 2'(s); req_vaddr = 32'hFFFF_FFFF; utlb_ppn = 19'h5_A5A5;
            set_all(2'd1, 1'b1, 1'b0, 2'b00, 1'b1, 2'b11, 1'b1); run_req();
        end
        // R11: valid drops when no request
        @(negedge clk);
        chk("R11 idle valid", 32'(rsp_valid), 0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            req_kind = 2'($urandom_range(0, 3)); priv = 1'($urandom);
            itlb_hit = 1'($urandom); itlb_pr = 2'($urandom);
            utlb_hit = 1'($urandom); utlb_pr = 2'($urandom); utlb_dirty = 1'($urandom);
            itlb_ppn = PPN_W'($urandom); utlb_ppn = PPN_W'($urandom);
            itlb_size = 2'($urandom); utlb_size = 2'($urandom);
            req_vaddr = $urandom; sv_mode = 1'($urandom);
            run_req();
            if (n % 7 == 0) begin
                @(negedge clk);
                chk("R11 gap valid", 32'(rsp_valid), 0);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule